// File: doc/BRIEF.md
# Collision-Safe Dual-Port RAM

This block is a single-clock memory with two independent ports, A and B. Each port has its own address, write data, write enable and registered read data. On any cycle, each port may read or write any word. A write that is accepted updates the array at the clock edge. A read returns the word as it stood before that edge, so a port that reads an address being written in the same cycle receives the previous contents.

When both ports write the same word in the same cycle, the block does not leave an undefined result. A parameter names the winning port, and the losing port's write is suppressed for that cycle. The losing port then receives a one-cycle `lost` pulse.

A partition parameter can give each port a write window, set by a base and a limit address. Writes outside the window are dropped and raise a one-cycle `viol` pulse, while reads still reach the whole array. The windows may overlap, and a collision can only occur inside the overlap.

Top module: `shared_dpram`

## Requirements
- R1: While reset is asserted, both read-data outputs and the four flag outputs (`a_lost`, `b_lost`, `a_viol`, `b_viol`) are 0.
- R2: Read data appears on a port's `rdata` one clock edge after the address is presented, and a word written through either port can be read back through either port.
- R3: A read of an address that is written in the same cycle returns the word held before that write.
- R4: Two accepted writes to different addresses in the same cycle both take effect.
- R5: When both ports write the same address in the same cycle, only the winner's data is stored. With the default `WINNER = WIN_A`, port A wins.
- R6: With `WINNER = WIN_B`, port B wins a same-address collision.
- R7: The losing port's `lost` output is 1 for exactly the one cycle after the colliding edge. The winner's `lost` output stays 0, and the two `lost` outputs are never high together.
- R8: With `PART_EN = 1`, a write outside the port's window leaves the memory unchanged, and that port's `viol` output is 1 for the cycle after the write. Port A's window is `A_BASE`..`A_LIMIT` (default 0..39), and port B's window is `B_BASE`..`B_LIMIT` (default 24..63).
- R9: With partitioning enabled, either port can read any address, including addresses in the other port's window.
- R10: With `PART_EN = 0`, either port can write any address, and `viol` never rises.
- R11: A write dropped for being outside its window takes no part in collision resolution. If the other port writes the same address from inside its own window, that write completes and no `lost` pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset for outputs and flags |
| a_addr | input | AW | Port A address |
| a_wdata | input | WIDTH | Port A write data |
| a_we | input | 1 | Port A write enable |
| a_rdata | output | WIDTH | Port A read data, one cycle latency |
| a_lost | output | 1 | Port A write lost a collision (pulse) |
| a_viol | output | 1 | Port A wrote outside its window (pulse) |
| b_addr | input | AW | Port B address |
| b_wdata | input | WIDTH | Port B write data |
| b_we | input | 1 | Port B write enable |
| b_rdata | output | WIDTH | Port B read data, one cycle latency |
| b_lost | output | 1 | Port B write lost a collision (pulse) |
| b_viol | output | 1 | Port B wrote outside its window (pulse) |

## Verification
The main function is exercised with:
- writes from both ports to separate addresses, to show that neither port blocks the other;
- cross reads, to show that both ports see one array;
- reads that overlap a write, to separate old-data returns from write-through;
- same-address writes inside the window overlap, to show which data survives and which port is flagged;
- a write from outside a window that meets a legal write to the same word, to show that a rejected write is not treated as a collision.

A second instance, with partitioning off and port B preferred, is given the same collision pattern. This shows that the winner choice follows the parameter and that windows no longer apply.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    typedef enum logic {
        WIN_A = 1'b0,
        WIN_B = 1'b1
    } winner_e;
endpackage

// File: rtl/dp_window_gate.sv
module dp_window_gate #(
    parameter int unsigned AW      = 6,
    parameter bit          PART_EN = 1'b1,
    parameter int unsigned BASE    = 0,
    parameter int unsigned LIMIT   = 63
) (
    input  logic [AW-1:0] addr,
    input  logic          we,
    output logic          we_ok,
    output logic          viol
);
    logic in_win;

    generate
        if (PART_EN) begin : g_part
            logic [31:0] addr_w;
            assign addr_w = 32'(addr);
            assign in_win = (addr_w >= BASE) && (addr_w <= LIMIT);
        end else begin : g_open
            assign in_win = 1'b1;
        end
    endgenerate

    assign we_ok = we & in_win;
    assign viol  = we & ~in_win;
endmodule

// File: rtl/dp_collide_arb.sv
module dp_collide_arb
    import dpram_pkg::*;
#(
    parameter int unsigned AW     = 6,
    parameter winner_e     WINNER = WIN_A
) (
    input  logic [AW-1:0] a_addr,
    input  logic          a_we_ok,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we_ok,
    output logic          a_we_fin,
    output logic          b_we_fin,
    output logic          a_drop,
    output logic          b_drop
);
    logic clash;

    always_comb begin
        clash    = a_we_ok && b_we_ok && (a_addr == b_addr);
        a_drop   = 1'b0;
        b_drop   = 1'b0;
        unique case (WINNER)
            WIN_A: b_drop = clash;
            WIN_B: a_drop = clash;
        endcase
        a_we_fin = a_we_ok & ~a_drop;
        b_we_fin = b_we_ok & ~b_drop;
    end
endmodule

// File: rtl/dp_mem_core.sv
module dp_mem_core #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WIDTH = 16,
    parameter int unsigned AW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    input  logic             a_we,
    output logic [WIDTH-1:0] a_rdata,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    input  logic             b_we,
    output logic [WIDTH-1:0] b_rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    // Arbitration upstream guarantees a_we and b_we never share an address.
    always_ff @(posedge clk) begin
        if (a_we) store[a_addr] <= a_wdata;
        if (b_we) store[b_addr] <= b_wdata;
    end

    // Read-old-data: the sample is taken before this edge's writes land.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            a_rdata <= store[a_addr];
            b_rdata <= store[b_addr];
        end
    end
endmodule

// File: rtl/shared_dpram.sv
module shared_dpram
    import dpram_pkg::*;
#(
    parameter int unsigned DEPTH   = 64,
    parameter int unsigned WIDTH   = 16,
    parameter winner_e     WINNER  = WIN_A,
    parameter bit          PART_EN = 1'b1,
    parameter int unsigned A_BASE  = 0,
    parameter int unsigned A_LIMIT = 39,
    parameter int unsigned B_BASE  = 24,
    parameter int unsigned B_LIMIT = 63,
    localparam int unsigned AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    input  logic             a_we,
    output logic [WIDTH-1:0] a_rdata,
    output logic             a_lost,
    output logic             a_viol,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    input  logic             b_we,
    output logic [WIDTH-1:0] b_rdata,
    output logic             b_lost,
    output logic             b_viol
);
    logic a_we_ok, b_we_ok;
    logic a_viol_now, b_viol_now;
    logic a_we_fin, b_we_fin;
    logic a_drop, b_drop;

    dp_window_gate #(
        .AW(AW), .PART_EN(PART_EN), .BASE(A_BASE), .LIMIT(A_LIMIT)
    ) u_gate_a (
        .addr(a_addr), .we(a_we), .we_ok(a_we_ok), .viol(a_viol_now)
    );

    dp_window_gate #(
        .AW(AW), .PART_EN(PART_EN), .BASE(B_BASE), .LIMIT(B_LIMIT)
    ) u_gate_b (
        .addr(b_addr), .we(b_we), .we_ok(b_we_ok), .viol(b_viol_now)
    );

    dp_collide_arb #(
        .AW(AW), .WINNER(WINNER)
    ) u_arb (
        .a_addr(a_addr), .a_we_ok(a_we_ok),
        .b_addr(b_addr), .b_we_ok(b_we_ok),
        .a_we_fin(a_we_fin), .b_we_fin(b_we_fin),
        .a_drop(a_drop), .b_drop(b_drop)
    );

    dp_mem_core #(
        .DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we_fin), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we_fin), .b_rdata(b_rdata)
    );

    // One-cycle event pulses, registered so they line up with read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_lost <= 1'b0;
            b_lost <= 1'b0;
            a_viol <= 1'b0;
            b_viol <= 1'b0;
        end else begin
            a_lost <= a_drop;
            b_lost <= b_drop;
            a_viol <= a_viol_now;
            b_viol <= b_viol_now;
        end
    end
endmodule

// File: rtl/shared_dpram_chk.sv
module shared_dpram_chk #(
    parameter int unsigned AW      = 6,
    parameter bit          WIN_B_P = 1'b0,
    parameter bit          PART_EN = 1'b1,
    parameter int unsigned A_BASE  = 0,
    parameter int unsigned A_LIMIT = 39,
    parameter int unsigned B_BASE  = 24,
    parameter int unsigned B_LIMIT = 63
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] a_addr,
    input logic          a_we,
    input logic [AW-1:0] b_addr,
    input logic          b_we,
    input logic          a_lost,
    input logic          b_lost,
    input logic          a_viol,
    input logic          b_viol
);
    logic a_in, b_in, both_in_same;
    assign a_in = !PART_EN || ((32'(a_addr) >= A_BASE) && (32'(a_addr) <= A_LIMIT));
    assign b_in = !PART_EN || ((32'(b_addr) >= B_BASE) && (32'(b_addr) <= B_LIMIT));
    assign both_in_same = a_we && b_we && a_in && b_in && (a_addr == b_addr);

    AST_LOST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_lost && b_lost)); // R7
    AST_A_LOST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        a_lost |-> $past(a_we && b_we && (a_addr == b_addr))); // R5
    AST_B_LOST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        b_lost |-> $past(a_we && b_we && (a_addr == b_addr))); // R5
    AST_WINNER_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        both_in_same |=> (WIN_B_P ? (a_lost && !b_lost) : (b_lost && !a_lost))); // R6
    AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_viol || b_viol) |-> $past(a_we || b_we)); // R8
    AST_VIOL_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_lost && a_viol) && !(b_lost && b_viol)); // R11
    AST_OPEN_NO_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        !PART_EN |-> (!a_viol && !b_viol)); // R10
endmodule

bind shared_dpram shared_dpram_chk #(
    .AW(AW), .WIN_B_P(WINNER == dpram_pkg::WIN_B), .PART_EN(PART_EN),
    .A_BASE(A_BASE), .A_LIMIT(A_LIMIT), .B_BASE(B_BASE), .B_LIMIT(B_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_we(a_we), .b_addr(b_addr), .b_we(b_we),
    .a_lost(a_lost), .b_lost(b_lost), .a_viol(a_viol), .b_viol(b_viol)
);

// File: tb/shared_dpram_bench.sv
module shared_dpram_bench;
    import dpram_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    typedef struct packed {
        logic [5:0]  a_addr;
        logic [15:0] a_wd;
        logic        a_we;
        logic [5:0]  b_addr;
        logic [15:0] b_wd;
        logic        b_we;
        logic        chk_a;
        logic [15:0] exp_a;
        logic        chk_b;
        logic [15:0] exp_b;
        logic        exp_al;
        logic        exp_bl;
        logic        exp_av;
        logic        exp_bv;
    } vec_t;

    // Windows: A 0..39, B 24..63; port A wins collisions.
    localparam vec_t TBL [NV] = '{
        '{6'd5,  16'h1111, 1'b1, 6'd40, 16'h2222, 1'b1, 1'b0, 16'h0,    1'b0, 16'h0,    1'b0, 1'b0, 1'b0, 1'b0}, // R4
        '{6'd40, 16'h0,    1'b0, 6'd5,  16'h0,    1'b0, 1'b1, 16'h2222, 1'b1, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 R9
        '{6'd5,  16'h3333, 1'b1, 6'd5,  16'h0,    1'b0, 1'b1, 16'h1111, 1'b1, 16'h1111, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
        '{6'd5,  16'h0,    1'b0, 6'd5,  16'h4444, 1'b1, 1'b1, 16'h3333, 1'b1, 16'h3333, 1'b0, 1'b0, 1'b0, 1'b1}, // R8
        '{6'd5,  16'h0,    1'b0, 6'd40, 16'h0,    1'b0, 1'b1, 16'h3333, 1'b1, 16'h2222, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
        '{6'd50, 16'h5555, 1'b1, 6'd50, 16'h6666, 1'b1, 1'b0, 16'h0,    1'b0, 16'h0,    1'b0, 1'b0, 1'b1, 1'b0}, // R11
        '{6'd50, 16'h0,    1'b0, 6'd50, 16'h0,    1'b0, 1'b1, 16'h6666, 1'b1, 16'h6666, 1'b0, 1'b0, 1'b0, 1'b0}, // R11
        '{6'd30, 16'h7777, 1'b1, 6'd30, 16'h8888, 1'b1, 1'b0, 16'h0,    1'b0, 16'h0,    1'b0, 1'b1, 1'b0, 1'b0}, // R5 R7
        '{6'd30, 16'h0,    1'b0, 6'd30, 16'h0,    1'b0, 1'b1, 16'h7777, 1'b1, 16'h7777, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 R7
        '{6'd10, 16'hAAAA, 1'b1, 6'd60, 16'hBBBB, 1'b1, 1'b0, 16'h0,    1'b0, 16'h0,    1'b0, 1'b0, 1'b0, 1'b0}, // R4
        '{6'd60, 16'h0,    1'b0, 6'd10, 16'h0,    1'b0, 1'b1, 16'hBBBB, 1'b1, 16'hAAAA, 1'b0, 1'b0, 1'b0, 1'b0}  // R4
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0]  a_addr = '0, b_addr = '0;
    logic [15:0] a_wdata = '0, b_wdata = '0;
    logic        a_we = 1'b0, b_we = 1'b0;
    logic [15:0] a_rdata, b_rdata, x_a_rdata, x_b_rdata;
    logic        a_lost, b_lost, a_viol, b_viol;
    logic        x_a_lost, x_b_lost, x_a_viol, x_b_viol;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_dpram u_shared_dpram (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_rdata(a_rdata),
        .a_lost(a_lost), .a_viol(a_viol),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_rdata(b_rdata),
        .b_lost(b_lost), .b_viol(b_viol)
    );

    // Second copy: no windows, port B preferred; shares the stimulus.
    shared_dpram #(.WINNER(WIN_B), .PART_EN(1'b0)) u_shared_dpram_open (
        .clk(clk), .rst_n(rst_n),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_rdata(x_a_rdata),
        .a_lost(x_a_lost), .a_viol(x_a_viol),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_rdata(x_b_rdata),
        .b_lost(x_b_lost), .b_viol(x_b_viol)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [5:0] aa, input logic [15:0] awd, input logic awe,
                        input logic [5:0] ba, input logic [15:0] bwd, input logic bwe);
        @(negedge clk);
        a_addr = aa; a_wdata = awd; a_we = awe;
        b_addr = ba; b_wdata = bwd; b_we = bwe;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 a_rdata", 32'(a_rdata), 0);
        check("R1 b_rdata", 32'(b_rdata), 0);
        check("R1 flags", {a_lost, b_lost, a_viol, b_viol}, 0);
        check("R1 open flags", {x_a_lost, x_b_lost, x_a_viol, x_b_viol}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].a_addr, TBL[i].a_wd, TBL[i].a_we,
                 TBL[i].b_addr, TBL[i].b_wd, TBL[i].b_we);
            if (TBL[i].chk_a) check($sformatf("R2/R3 vec%0d a_rdata", i), 32'(a_rdata), 32'(TBL[i].exp_a));
            if (TBL[i].chk_b) check($sformatf("R2/R3 vec%0d b_rdata", i), 32'(b_rdata), 32'(TBL[i].exp_b));
            check($sformatf("R7 vec%0d lost", i), {a_lost, b_lost}, {TBL[i].exp_al, TBL[i].exp_bl});
            check($sformatf("R8 vec%0d viol", i), {a_viol, b_viol}, {TBL[i].exp_av, TBL[i].exp_bv});
        end

        // Directed on the open copy: same-address collision, B preferred.
        step(6'd5, 16'h1234, 1'b1, 6'd5, 16'h5678, 1'b1);
        check("R6 open a_lost", 32'(x_a_lost), 1);
        check("R6 open b_lost", 32'(x_b_lost), 0);
        step(6'd5, 16'h0, 1'b0, 6'd5, 16'h0, 1'b0);
        check("R6 open a_rdata", 32'(x_a_rdata), 32'h5678);
        check("R6 open b_rdata", 32'(x_b_rdata), 32'h5678);
        check("R7 open lost cleared", {x_a_lost, x_b_lost}, 0);
        check("R5 windowed A wins addr5", 32'(a_rdata), 32'h1234);
        check("R7 windowed lost", {a_lost, b_lost}, 0);

        // Open copy: A writes high, B writes low, no violations anywhere.
        step(6'd60, 16'hC0DE, 1'b1, 6'd2, 16'hBEEF, 1'b1);
        check("R10 open viol", {x_a_viol, x_b_viol}, 0);
        check("R8 windowed both viol", {a_viol, b_viol}, 2'b11);
        step(6'd2, 16'h0, 1'b0, 6'd60, 16'h0, 1'b0);
        check("R10 open b reads A write", 32'(x_b_rdata), 32'hC0DE);
        check("R10 open a reads B write", 32'(x_a_rdata), 32'hBEEF);
        check("R8 windowed viol cleared", {a_viol, b_viol}, 0);
        check("R8 windowed addr60 kept", 32'(b_rdata), 32'hBBBB);

        // Reset mid-run clears outputs again.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 re-reset a_rdata", 32'(a_rdata), 0);
        check("R1 re-reset b_rdata", 32'(b_rdata), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule